// File: doc/BRIEF.md
# Per-CPU Interrupt Level Combiner

This block is the interrupt register and level generator for one processor. It merges three sources into a 16-bit level vector, `lvl_out`. Bit k of that vector requests priority level k, and level 0 does not exist. The three sources are:

- the hard level vector that the system router has already computed for this CPU;
- software interrupts, which are set and cleared through a small word-addressed register port;
- two dedicated lines: a level-15 broadcast line shared by all CPUs, and this CPU's own timer line.

Software reads one pending word that shows all of these together. When this CPU is the current interrupt target, the word also shows a display copy of the hard levels. That copy is derived from every pending system source, including sources that are disabled. The global master-disable flag and the target-select flag come from the system-level register file as plain inputs.

Register offsets are word offsets, and only full 32-bit accesses exist:

- offset 0 reads the pending word;
- offset 1 is the clear port;
- offset 2 is the set port.

The output vector is registered, so every level line changes only on a clock edge.

Top module: `cpu_level_combiner`

## Requirements
- R1: Pending bits 31..17 hold the soft interrupts. Soft bit b drives level b-16 (levels 1..15).
- R2: A write to word offset 2 ORs write data bits 31..17 into the soft field. All other bits of the data are ignored.
- R3: A write to word offset 1 clears the soft bits selected by data bits 31..17. It also clears pending bit 15 if data bit 15 is set. No other bit is cleared.
- R4: A read at word offset 0 returns the pending word. A read at any other offset returns zero.
- R5: Pending bit 14 equals the timer line as sampled at the previous edge. Pending bit 15 is set on a rising edge of the broadcast line and cleared on a falling edge.
- R6: Pending bits 14 and 15 drive levels 14 and 15 only while `master_off` is low.
- R7: While `is_target` is high, pending bits 15..1 also show `disp_lvl_in[15:1]` ORed in. While it is low, no display bits appear.
- R8: `lvl_out[0]` is always zero.
- R9: After reset the pending word and `lvl_out` are zero.
- R10: At each edge `lvl_out` loads the OR of three terms: the soft levels, the gated bit-14/15 levels and `hard_lvl_in[15:1]`. These come from the register state and inputs present before that edge.
- R11: A write to offset 0 or to any offset from 3 upward changes nothing.
- R12: When a broadcast rising edge and a clear of bit 15 fall in the same cycle, bit 15 ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | ADDR_W | Word offset of the write |
| bus_wdata | input | 32 | Write data |
| rd_addr | input | ADDR_W | Word offset of the read |
| rd_data | output | 32 | Read data (combinational) |
| hard_lvl_in | input | 16 | Hard level vector from the router |
| disp_lvl_in | input | 16 | Display hard levels from all pending sources |
| is_target | input | 1 | This CPU is the current hard-interrupt target |
| master_off | input | 1 | Global master disable |
| bcast15_in | input | 1 | Broadcast level-15 line |
| timer_in | input | 1 | This CPU's timer line |
| lvl_out | output | 16 | Registered level request vector |

## Verification
Pending bit 15 has two writers that can act in the same cycle: the broadcast edge detector and the clear port. The bench drives a broadcast rising edge in the same cycle as a clear write that selects bit 15, and expects the bit to read as set. In a separate step it clears bit 15 while the line is held high with no new edge, and expects the bit to read as clear. A second overlap is checked by sweeping master disable, broadcast and timer through all eight combinations. For each one, the bench compares the pending word, which is never gated, with the gated level outputs.

// File: rtl/plc_pkg.sv
package plc_pkg;
    localparam int WORD_W  = 32;
    localparam int LVL_N   = 16;
    localparam int SOFT_W  = LVL_N - 1;
    localparam int SOFT_LO = WORD_W - SOFT_W;
    localparam int TMR_BIT = LVL_N - 2;
    localparam int BC_BIT  = LVL_N - 1;

    localparam int OFS_PEND = 0;
    localparam int OFS_CLR  = 1;
    localparam int OFS_SET  = 2;

    typedef struct packed {
        logic b15;
        logic tmr;
    } line_state_t;

    function automatic logic [LVL_N-1:0] soft_to_lvl(input logic [SOFT_W-1:0] s);
        return {s, 1'b0};
    endfunction

    function automatic logic [LVL_N-1:0] line_to_lvl(input line_state_t l, input logic off);
        logic [LVL_N-1:0] v;
        v = '0;
        if (!off) begin
            v[BC_BIT]  = l.b15;
            v[TMR_BIT] = l.tmr;
        end
        return v;
    endfunction
endpackage

// File: rtl/plc_soft_bank.sv
module plc_soft_bank
    import plc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [SOFT_W-1:0] wsoft,
    output logic [SOFT_W-1:0] soft_q
);
    always_ff @(posedge clk) begin
        if (rst)
            soft_q <= '0;
        else if (set_en)
            soft_q <= soft_q | wsoft;
        else if (clr_en)
            soft_q <= soft_q & ~wsoft;
    end
endmodule

// File: rtl/plc_line_track.sv
module plc_line_track
    import plc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bcast_in,
    input  logic        timer_in,
    input  logic        clr_b15,
    output line_state_t line_q
);
    logic bc_prev;
    logic bc_rise;
    logic bc_fall;

    assign bc_rise = bcast_in & ~bc_prev;
    assign bc_fall = ~bcast_in & bc_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            bc_prev <= 1'b0;
            line_q  <= '0;
        end else begin
            bc_prev    <= bcast_in;
            line_q.tmr <= timer_in;
            if (bc_rise)
                line_q.b15 <= 1'b1;
            else if (bc_fall || clr_b15)
                line_q.b15 <= 1'b0;
        end
    end
endmodule

// File: rtl/plc_level_out.sv
module plc_level_out
    import plc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SOFT_W-1:0] soft_q,
    input  line_state_t       line_q,
    input  logic              master_off,
    input  logic [LVL_N-1:0]  hard_lvl,
    output logic [LVL_N-1:0]  lvl_q
);
    logic [LVL_N-1:0] lvl_d;

    always_comb begin
        lvl_d = soft_to_lvl(soft_q) | line_to_lvl(line_q, master_off) | hard_lvl;
        lvl_d[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            lvl_q <= '0;
        else
            lvl_q <= lvl_d;
    end
endmodule

// File: rtl/cpu_level_combiner.sv
module cpu_level_combiner
    import plc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic [LVL_N-1:0]  hard_lvl_in,
    input  logic [LVL_N-1:0]  disp_lvl_in,
    input  logic              is_target,
    input  logic              master_off,
    input  logic              bcast15_in,
    input  logic              timer_in,
    output logic [LVL_N-1:0]  lvl_out
);
    logic              wr_set;
    logic              wr_clr;
    logic [SOFT_W-1:0] soft_q;
    line_state_t       line_q;
    logic [WORD_W-1:0] pend_word;
    logic [LVL_N-1:0]  disp_bits;

    assign wr_set = bus_wr && (bus_addr == ADDR_W'(OFS_SET));
    assign wr_clr = bus_wr && (bus_addr == ADDR_W'(OFS_CLR));

    plc_soft_bank u_soft (
        .clk    (clk),
        .rst    (rst),
        .set_en (wr_set),
        .clr_en (wr_clr),
        .wsoft  (bus_wdata[WORD_W-1:SOFT_LO]),
        .soft_q (soft_q)
    );

    plc_line_track u_line (
        .clk      (clk),
        .rst      (rst),
        .bcast_in (bcast15_in),
        .timer_in (timer_in),
        .clr_b15  (wr_clr && bus_wdata[BC_BIT]),
        .line_q   (line_q)
    );

    plc_level_out u_lvl (
        .clk        (clk),
        .rst        (rst),
        .soft_q     (soft_q),
        .line_q     (line_q),
        .master_off (master_off),
        .hard_lvl   (hard_lvl_in),
        .lvl_q      (lvl_out)
    );

    always_comb begin
        disp_bits = is_target ? disp_lvl_in : '0;
        disp_bits[0] = 1'b0;
        pend_word = '0;
        pend_word[WORD_W-1:SOFT_LO] = soft_q;
        pend_word[BC_BIT]  = line_q.b15;
        pend_word[TMR_BIT] = line_q.tmr;
        pend_word[LVL_N-1:0] = pend_word[LVL_N-1:0] | disp_bits;
        rd_data = (rd_addr == ADDR_W'(OFS_PEND)) ? pend_word : '0;
    end
endmodule

// File: rtl/cpu_level_combiner_sva.sv
module cpu_level_combiner_sva
    import plc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic              timer_in,
    input logic              master_off,
    input logic [LVL_N-1:0]  hard_lvl_in,
    input logic [SOFT_W-1:0] soft_q,
    input logic              tmr_q,
    input logic [LVL_N-1:0]  lvl_out
);
    a_r8_no_level_zero: assert property (@(posedge clk) disable iff (rst)
        !rst |=> lvl_out[0] == 1'b0);

    a_r2_set_lands: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFS_SET))
        |=> ((soft_q & $past(bus_wdata[WORD_W-1:SOFT_LO])) == $past(bus_wdata[WORD_W-1:SOFT_LO])));

    a_r3_clear_lands: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFS_CLR))
        |=> ((soft_q & $past(bus_wdata[WORD_W-1:SOFT_LO])) == '0));

    a_r11_other_write_inert: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr != ADDR_W'(OFS_CLR) && bus_addr != ADDR_W'(OFS_SET))
        |=> $stable(soft_q));

    a_r5_timer_follows: assert property (@(posedge clk) disable iff (rst)
        !rst |=> tmr_q == $past(timer_in));

    a_r6_gated_top: assert property (@(posedge clk) disable iff (rst)
        master_off |=> (lvl_out[15:14] == ($past(hard_lvl_in[15:14]) | $past(soft_q[14:13]))));
endmodule

bind cpu_level_combiner cpu_level_combiner_sva #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .timer_in    (timer_in),
    .master_off  (master_off),
    .hard_lvl_in (hard_lvl_in),
    .soft_q      (soft_q),
    .tmr_q       (line_q.tmr),
    .lvl_out     (lvl_out)
);

// File: tb/cpu_level_combiner_tb_top.sv
module cpu_level_combiner_tb_top;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;
    logic [15:0]   hard_lvl_in = '0;
    logic [15:0]   disp_lvl_in = '0;
    logic          is_target = 1'b0;
    logic          master_off = 1'b0;
    logic          bcast15_in = 1'b0;
    logic          timer_in = 1'b0;
    logic [15:0]   lvl_out;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [14:0] m_soft = '0;
    logic        m_b15 = 1'b0;

    always #5 clk = ~clk;

    cpu_level_combiner #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
        .hard_lvl_in(hard_lvl_in), .disp_lvl_in(disp_lvl_in),
        .is_target(is_target), .master_off(master_off),
        .bcast15_in(bcast15_in), .timer_in(timer_in), .lvl_out(lvl_out)
    );

    function automatic logic [31:0] exp_pend();
        logic [31:0] p;
        p = {m_soft, 17'b0};
        p[15] = m_b15;
        p[14] = timer_in;
        if (is_target) p[15:1] = p[15:1] | disp_lvl_in[15:1];
        return p;
    endfunction

    function automatic logic [15:0] exp_lvl();
        logic [15:0] v;
        v = {m_soft, 1'b0} | {hard_lvl_in[15:1], 1'b0};
        if (!master_off) v = v | {m_b15, timer_in, 14'b0};
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic check_all(input string req);
        rd_addr = 0;
        #1;
        chk(req, rd_data, exp_pend());
        chk(req, {16'b0, lvl_out}, {16'b0, exp_lvl()});
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        bus_wr = 1'b1;
        bus_addr = AW'(a);
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 2) m_soft = m_soft | d[31:17];
        if (a == 1) begin
            m_soft = m_soft & ~d[31:17];
            if (d[15]) m_b15 = 1'b0;
        end
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired got=1 exp=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        rd_addr = 0;
        #1;
        chk("R9 pend", rd_data, 32'h0);
        chk("R9 lvl", {16'b0, lvl_out}, 32'h0);

        // R1 R2 R3: each soft bit set with junk low bits, then cleared
        for (int b = 17; b < 32; b++) begin
            wr(2, (32'h1 << b) | 32'h0001_FFFF);
            check_all("R2 R1 set");
            wr(1, 32'h1 << b);
            check_all("R3 clear");
        end

        // R11 writes to undefined offsets change nothing
        wr(2, 32'hFFFF_FFFF);
        check_all("R2 all");
        for (int a = 0; a < 16; a++) begin
            if (a == 1 || a == 2) continue;
            wr(a, 32'h0000_0000);
            wr(a, 32'hFFFF_FFFF);
            check_all("R11 ignore");
        end
        wr(1, 32'hFFFF_FFFF);
        check_all("R3 all");
        for (int a = 3; a < 16; a++) begin
            wr(a, 32'hFFFF_FFFF);
        end
        check_all("R11 no set");

        // R5 R6 R8: master/bcast/timer sweep, plus hard bit 0 never shows
        hard_lvl_in = 16'h0001;
        for (int c = 0; c < 8; c++) begin
            master_off = c[0];
            if (bcast15_in != c[1]) m_b15 = c[1];
            bcast15_in = c[1];
            timer_in = c[2];
            settle();
            check_all("R5 R6 R8 sweep");
        end

        // R3 clear bit15 while line held high (no new edge)
        master_off = 1'b0;
        bcast15_in = 1'b1;
        timer_in = 1'b0;
        settle();
        wr(1, 32'h0000_8000);
        check_all("R3 b15 clear");

        // R12 rising edge coincides with clear of bit 15: set wins
        bcast15_in = 1'b0;
        m_b15 = 1'b0;
        settle();
        bus_wr = 1'b1;
        bus_addr = AW'(1);
        bus_wdata = 32'h0000_8000;
        bcast15_in = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        m_b15 = 1'b1;
        @(negedge clk);
        check_all("R12 rise beats clear");

        // R7 R10: display and hard patterns with target on/off
        for (int t = 0; t < 2; t++) begin
            for (int p = 0; p < 4; p++) begin
                is_target = t[0];
                disp_lvl_in = (p == 0) ? 16'hAAAA : (p == 1) ? 16'h5555 : (p == 2) ? 16'hFFFF : 16'h0000;
                hard_lvl_in = (p == 0) ? 16'h5555 : (p == 1) ? 16'h1234 : (p == 2) ? 16'h0001 : 16'hFFFF;
                settle();
                check_all("R7 R10 pattern");
            end
        end

        // R4 reads at other offsets return zero
        wr(2, 32'hA5A4_0000);
        for (int a = 1; a < 16; a++) begin
            rd_addr = AW'(a);
            #1;
            chk("R4 other read", rd_data, 32'h0);
        end
        check_all("R4 pend read");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule